// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the source (read) and destination (write) byte addresses for a single DMA channel as it works through a sequence of bus transfers. A configuration register holds the transfer width, an increment enable for each side, a ring size and a ring side select. A trigger pulse loads both start addresses. After that, each accepted beat advances the addresses according to the configuration in effect at that time.

Ring mode keeps the bits above the lowest n bits of the chosen address fixed, and lets only those low bits count. The address then loops over an aligned buffer of 2^n bytes. Only one side is ever wrapped. The other side advances linearly, or holds its value if its increment is off.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both addresses are 0. The configuration is read increment on, write increment off, ring select on the read side, ring size 0 and word transfers.
- R2: Size code 0 steps an incrementing address by 1 byte per beat. Code 1 steps it by 2 bytes, and code 2 by 4 bytes. Code 3 behaves as code 2.
- R3: With read increment off, `rd_addr` keeps its value across beats.
- R4: With write increment off, `wr_addr` keeps its value across beats.
- R5: A ring size of 0 disables wrapping, so carries pass into every address bit.
- R6: A ring size n from 1 to 15 makes a beat produce `(a & ~m) | ((a + step) & m)`, where m = 2^n - 1. The bits above bit n-1 never change.
- R7: Ring select 1 applies the ring to the write address and ring select 0 applies it to the read address. The side that is not selected never wraps.
- R8: A `trigger` pulse loads `rd_start` and `wr_start` into the addresses on the next clock edge. This load takes precedence over a beat in the same cycle.
- R9: The addresses change only on a trigger or an accepted beat. A configuration write or an idle cycle leaves them unchanged.
- R10: A configuration write takes effect for beats in the cycles after it. A beat in the same cycle as the write still uses the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Writes the configuration fields below |
| cfg_rd_inc | input | 1 | Read increment enable |
| cfg_wr_inc | input | 1 | Write increment enable |
| cfg_size | input | 2 | Transfer size code (0 byte, 1 halfword, 2 or 3 word) |
| cfg_ring_n | input | 4 | Ring size in bits, 0 disables wrapping |
| cfg_ring_wr | input | 1 | Ring side select: 1 write side, 0 read side |
| trigger | input | 1 | Loads the start addresses |
| rd_start | input | AW | Start read address |
| wr_start | input | AW | Start write address |
| beat | input | 1 | Accepted transfer beat, advances the addresses |
| rd_addr | output | AW | Current read address |
| wr_addr | output | AW | Current write address |

## Verification
The assertions assume that `trigger` and `beat` are plain single-cycle strobes that are sampled only out of reset. They also assume that the start addresses are stable in the cycle in which a trigger is sampled. The bench drives every input on the falling clock edge, so each strobe and each address is steady across the rising edge that samples it. Random phases choose the size, the ring size from 0 to 15, the ring side and the start addresses, and they mix beats with idle cycles and configuration writes. Directed cases cover the reset defaults, a carry past bit 15 with the ring off, a trigger in the same cycle as a beat, and a configuration write in the same cycle as a beat.

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_rd_inc,
  input  logic          cfg_wr_inc,
  input  logic [1:0]    cfg_size,
  input  logic [3:0]    cfg_ring_n,
  input  logic          cfg_ring_wr,
  input  logic          trigger,
  input  logic [AW-1:0] rd_start,
  input  logic [AW-1:0] wr_start,
  input  logic          beat,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr
);
  logic          rd_inc_q, wr_inc_q, ring_wr_q;
  logic [1:0]    size_q;
  logic [3:0]    ring_n_q;
  logic [AW-1:0] step, ring_mask, rd_mask, wr_mask, rd_nxt, wr_nxt;

  assign step      = (size_q == 2'd0) ? AW'(1) : (size_q == 2'd1) ? AW'(2) : AW'(4);
  assign ring_mask = (AW'(1) << ring_n_q) - AW'(1);
  assign rd_mask   = (ring_n_q != 4'd0 && !ring_wr_q) ? ring_mask : '1;
  assign wr_mask   = (ring_n_q != 4'd0 &&  ring_wr_q) ? ring_mask : '1;

  assign rd_nxt = rd_inc_q ? ((rd_addr & ~rd_mask) | ((rd_addr + step) & rd_mask)) : rd_addr;
  assign wr_nxt = wr_inc_q ? ((wr_addr & ~wr_mask) | ((wr_addr + step) & wr_mask)) : wr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_inc_q  <= 1'b1;
      wr_inc_q  <= 1'b0;
      ring_wr_q <= 1'b0;
      ring_n_q  <= 4'd0;
      size_q    <= 2'd2;
    end else if (cfg_we) begin
      rd_inc_q  <= cfg_rd_inc;
      wr_inc_q  <= cfg_wr_inc;
      ring_wr_q <= cfg_ring_wr;
      ring_n_q  <= cfg_ring_n;
      size_q    <= cfg_size;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_addr <= '0;
      wr_addr <= '0;
    end else if (trigger) begin
      rd_addr <= rd_start;
      wr_addr <= wr_start;
    end else if (beat) begin
      rd_addr <= rd_nxt;
      wr_addr <= wr_nxt;
    end
  end
endmodule

module dma_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trigger,
  input logic          beat,
  input logic          cfg_we,
  input logic [AW-1:0] rd_start,
  input logic [AW-1:0] wr_start,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] wr_addr,
  input logic          rd_inc_q,
  input logic          wr_inc_q,
  input logic          ring_wr_q,
  input logic [3:0]    ring_n_q,
  input logic [AW-1:0] ring_mask
);
  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (rd_addr == $past(rd_start) && wr_addr == $past(wr_start))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trigger && !beat) |=> ($stable(rd_addr) && $stable(wr_addr))); // R9
  AST_RD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !trigger && !rd_inc_q) |=> $stable(rd_addr)); // R3
  AST_WR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !trigger && !wr_inc_q) |=> $stable(wr_addr)); // R4
  AST_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !trigger && !ring_wr_q && ring_n_q != 4'd0) |=>
      (((rd_addr ^ $past(rd_addr)) & ~$past(ring_mask)) == '0)); // R6
  AST_WR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !trigger && ring_wr_q && ring_n_q != 4'd0) |=>
      (((wr_addr ^ $past(wr_addr)) & ~$past(ring_mask)) == '0)); // R7
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .beat(beat), .cfg_we(cfg_we),
  .rd_start(rd_start), .wr_start(wr_start), .rd_addr(rd_addr), .wr_addr(wr_addr),
  .rd_inc_q(rd_inc_q), .wr_inc_q(wr_inc_q), .ring_wr_q(ring_wr_q),
  .ring_n_q(ring_n_q), .ring_mask(ring_mask)
);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_rd_inc = 0, cfg_wr_inc = 0, cfg_ring_wr = 0;
  logic [1:0] cfg_size = 0;
  logic [3:0] cfg_ring_n = 0;
  logic trigger = 0, beat = 0;
  logic [AW-1:0] rd_start = 0, wr_start = 0, rd_addr, wr_addr;
  int tests = 0, fails = 0;
  logic m_rinc, m_winc, m_rwr;
  logic [1:0] m_size;
  logic [3:0] m_n;
  logic [AW-1:0] e_rd, e_wr;

  always #10 clk = ~clk;

  dma_addr_gen #(.AW(AW)) uut (.*);

  function automatic logic [AW-1:0] adv(logic [AW-1:0] a, logic inc, logic ring, logic [3:0] n, logic [1:0] sz);
    logic [AW-1:0] st, m;
    st = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    m = (ring && n != 0) ? ((AW'(1) << n) - 1) : '1;
    if (!inc) return a;
    return (a & ~m) | ((a + st) & m);
  endfunction

  task automatic check(string req);
    tests++;
    if (rd_addr !== e_rd || wr_addr !== e_wr) begin
      fails++;
      $display("FAIL %s rd=%h wr=%h expected rd=%h wr=%h", req, rd_addr, wr_addr, e_rd, e_wr);
    end
  endtask

  task automatic step(logic t, logic b, logic w, logic ri, logic wi, logic [1:0] sz,
                      logic [3:0] n, logic rw, logic [AW-1:0] rs, logic [AW-1:0] ws, string req);
    trigger = t; beat = b; cfg_we = w; cfg_rd_inc = ri; cfg_wr_inc = wi;
    cfg_size = sz; cfg_ring_n = n; cfg_ring_wr = rw; rd_start = rs; wr_start = ws;
    @(posedge clk);
    if (t) begin e_rd = rs; e_wr = ws; end
    else if (b) begin
      e_rd = adv(e_rd, m_rinc, !m_rwr, m_n, m_size);
      e_wr = adv(e_wr, m_winc,  m_rwr, m_n, m_size);
    end
    if (w) begin m_rinc = ri; m_winc = wi; m_size = sz; m_n = n; m_rwr = rw; end
    @(negedge clk);
    trigger = 0; beat = 0; cfg_we = 0;
    check(req);
  endtask

  task automatic cfg(logic ri, logic wi, logic [1:0] sz, logic [3:0] n, logic rw, string req);
    step(0, 0, 1, ri, wi, sz, n, rw, 0, 0, req);
  endtask
  task automatic trig(logic [AW-1:0] rs, logic [AW-1:0] ws, string req);
    step(1, 0, 0, 0, 0, 0, 0, 0, rs, ws, req);
  endtask
  task automatic beats(int k, string req);
    for (int i = 0; i < k; i++) step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_rinc = 1; m_winc = 0; m_rwr = 0; m_size = 2; m_n = 0; e_rd = 0; e_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 reset addresses");
    trig(32'h1000, 32'h2000, "R8 load");
    beats(3, "R1 default config word read inc, write fixed");
    step(0, 0, 0, 0, 0, 0, 0, 0, 32'hdead, 32'hbeef, "R9 idle ignores start inputs");
    // R2 each size code
    for (int s = 0; s < 4; s++) begin
      cfg(1, 1, 2'(s), 0, 0, "R2 size cfg");
      beats(2, "R2 size step");
    end
    cfg(0, 1, 0, 0, 0, "R3 cfg");
    beats(2, "R3 read hold");
    cfg(1, 0, 1, 0, 1, "R4 cfg");
    beats(2, "R4 write hold");
    // R5 carry across bit 15 with ring off
    cfg(1, 1, 2, 0, 0, "R5 cfg");
    trig(32'h0000_fffc, 32'h0001_fffc, "R5 load");
    beats(2, "R5 no wrap carry");
    // R6/R7 read ring of 16 bytes
    cfg(1, 1, 2, 4, 0, "R6 cfg");
    trig(32'h3000_00f8, 32'h4000_00f8, "R6 load");
    beats(4, "R6 R7 read ring, write linear");
    cfg(1, 1, 1, 3, 1, "R7 cfg");
    trig(32'h5000_0004, 32'h6000_0004, "R7 load");
    beats(5, "R7 write ring, read linear");
    // R8 trigger beats beat
    step(1, 1, 0, 0, 0, 0, 0, 0, 32'h10, 32'h20, "R8 trigger over beat");
    // R10 config with beat uses old config
    cfg(1, 1, 2, 0, 0, "R10 cfg");
    step(0, 1, 1, 1, 1, 0, 0, 0, 0, 0, "R10 beat with cfg write uses old size");
    beats(1, "R10 new size applied");
    // random phases
    for (int p = 0; p < 300; p++) begin
      cfg(1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom), "R6 random cfg");
      trig($urandom, $urandom, "R8 random load");
      for (int k = 0; k < 20; k++) begin
        int r;
        r = $urandom_range(0, 9);
        if (r < 7) step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 R7 random beat");
        else if (r < 9) step(0, 0, 0, 0, 0, 0, 0, 0, $urandom, $urandom, "R9 random idle");
        else step(0, 1, 1, 1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom),
                  0, 0, "R10 random cfg with beat");
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule